// File: doc/BRIEF.md
# Memory Array Self-Test Engine

This block tests a single-port RAM whose words are arranged as a grid of rows and columns, each side a power of two in size. The engine sweeps the whole address space four times. It writes a generated data word everywhere, then reads every word back and compares it. It repeats both sweeps with every bit complemented. At the end it reports a pass/fail flag and the first address that failed. The RAM is shared between the engine and the normal functional requester through a multiplexer, so the functional path still works whenever no test owns the array.

The data generator is an index that counts modulo an odd period greater than one. Each index maps to a word through a multiply-and-add. Because the period is odd, it never divides a power-of-two row or column count. Two addresses a whole row or a whole column apart therefore never receive the same word over the full sweep. As a result, a dead decoder line, a row that aliases onto another row, or a column that aliases onto another column cannot produce a read-back equal to the expected word everywhere. Such a fault cannot slip through as a pass.

Top module: `mbist_engine`

## Requirements
- R1: After a synchronous reset, busy, done and fail are 0 and fail_addr is 0.
- R2: start is accepted only in a cycle where test_mode is 1 and no run is in progress. A start pulse while test_mode is 0, or while a run is busy, changes nothing.
- R3: A run visits addresses in ascending order, 0 to DEPTH-1, where address = row * 2^COL_BITS + col. It performs four sweeps: write all, read all, write all complemented, read all complemented. busy is 1 from the cycle after start is sampled until done rises. done rises 4*DEPTH+1 clock cycles after the edge that sampled start, and stays at 1 until the next accepted start.
- R4: In the plain sweeps, the word for address a is ((a mod PERIOD) * PAT_MUL + PAT_ADD) mod 2^DATA_W. In the complemented sweeps it is the bitwise inverse of that word. A fault-free run therefore leaves every address holding the inverse word. PERIOD is odd and greater than 1.
- R5: The RAM returns read data one cycle after the read request. Each read is compared in the following cycle. The first mismatch sets fail and loads fail_addr with the address that was read. Later mismatches leave both unchanged, and the run still completes.
- R6: A row-decoder fault that redirects every access of one row to its neighbouring row is reported as a failure at the first address where the read-back differs.
- R7: A column fault is reported. This covers a data bit stuck at 1 in every word of one column, and a column whose accesses are redirected to its neighbouring column.
- R8: A mismatch on address DEPTH-1 of the plain read sweep is reported. That compare falls in the same cycle as the first write of the complemented sweep.
- R9: While test_mode is 0 and no run is busy, the functional request (enable, write, address, data) drives the RAM unchanged. fn_rdata always shows the RAM read data.
- R10: While test_mode is 1 or a run is busy, functional requests never reach the RAM.
- R11: An accepted start clears done, fail and fail_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | Gives the RAM to the engine and enables start |
| start | input | 1 | Begins a run when accepted |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished (sticky until next start) |
| fail | output | 1 | A mismatch was seen in the last run |
| fail_addr | output | ROW_BITS+COL_BITS | First failing address |
| fn_en | input | 1 | Functional access request |
| fn_we | input | 1 | Functional write (1) or read (0) |
| fn_addr | input | ROW_BITS+COL_BITS | Functional address |
| fn_wdata | input | DATA_W | Functional write data |
| fn_rdata | output | DATA_W | Read data returned to the functional side |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ROW_BITS+COL_BITS | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, one cycle after the read |

## Verification
The compare for the last read of the plain sweep happens in the same cycle as the first write of the complemented sweep. A flipped bit is injected into the model RAM at address DEPTH-1 to target that cycle. The run must report that address and keep its total length. A second overlap is a start pulse and a continuous functional write presented in the middle of a busy run. The run must keep its cycle count and verdict. Afterwards, every address must hold the expected inverse word, which shows that neither request leaked through.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WR    = 2'd1,
    ST_RD    = 2'd2,
    ST_DRAIN = 2'd3
  } mbist_state_e;
endpackage

// File: rtl/mbist_patgen.sv
module mbist_patgen #(
  parameter int DATA_W  = 8,
  parameter int PERIOD  = 7,
  parameter int PAT_MUL = 37,
  parameter int PAT_ADD = 11,
  localparam int IDX_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              advance,
  input  logic              invert,
  output logic [DATA_W-1:0] pattern
);
  logic [IDX_W-1:0] idx_q;

  // modulo-PERIOD index; restart wins over advance
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (restart) begin
      idx_q <= '0;
    end else if (advance) begin
      idx_q <= (idx_q == IDX_W'(PERIOD - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  // word = idx * MUL + ADD, truncated to DATA_W, optionally complemented
  always_comb begin
    pattern = DATA_W'(idx_q) * DATA_W'(PAT_MUL) + DATA_W'(PAT_ADD);
    pattern = pattern ^ {DATA_W{invert}};
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(idx_q) < PERIOD); // R4
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 2,
  localparam int ADDR_W  = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_mode,
  input  logic              start,
  output logic              start_acc,
  output logic              busy,
  output logic              done,
  output logic              eng_en,
  output logic              eng_we,
  output logic [ADDR_W-1:0] eng_addr,
  output logic              invert,
  output logic              pat_restart,
  output logic              rd_issue
);
  mbist_state_e        state_q;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;
  logic                inv_q;
  logic                done_q;
  logic                last;

  assign last        = (&row_q) && (&col_q);
  assign busy        = (state_q != ST_IDLE);
  assign start_acc   = (state_q == ST_IDLE) && start && test_mode;
  assign eng_en      = (state_q == ST_WR) || (state_q == ST_RD);
  assign eng_we      = (state_q == ST_WR);
  assign rd_issue    = (state_q == ST_RD);
  assign eng_addr    = {row_q, col_q};
  assign invert      = inv_q;
  assign done        = done_q;
  assign pat_restart = start_acc || (eng_en && last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      inv_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_acc) begin
            state_q <= ST_WR;
            row_q   <= '0;
            col_q   <= '0;
            inv_q   <= 1'b0;
            done_q  <= 1'b0;
          end
        end
        ST_WR, ST_RD: begin
          // column counts fastest; both wrap to zero after the last word
          col_q <= col_q + 1'b1;
          if (&col_q) row_q <= row_q + 1'b1;
          if (last) begin
            if (state_q == ST_WR)  state_q <= ST_RD;
            else if (!inv_q) begin
              state_q <= ST_WR;
              inv_q   <= 1'b1;
            end else               state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(done_q && busy)); // R3
  AST_ADDR_RESTART: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (eng_addr == '0)); // R3
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && state_q != ST_DRAIN) |=> busy); // R2
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              rd_issue,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [DATA_W-1:0] issue_exp,
  input  logic [DATA_W-1:0] rd_data,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_exp_q;
  logic              fail_q;
  logic [ADDR_W-1:0] fail_addr_q;
  logic              mismatch;

  assign mismatch  = pend_q && (rd_data != pend_exp_q);
  assign fail      = fail_q;
  assign fail_addr = fail_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_exp_q  <= '0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      // read data comes back one cycle after the request
      pend_q      <= rd_issue;
      pend_addr_q <= issue_addr;
      pend_exp_q  <= issue_exp;
      if (clear) begin
        fail_q      <= 1'b0;
        fail_addr_q <= '0;
      end else if (mismatch && !fail_q) begin
        fail_q      <= 1'b1;
        fail_addr_q <= pend_addr_q;
      end
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !clear) |=> fail_q); // R5
  AST_FADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !clear) |=> $stable(fail_addr_q)); // R5
  AST_FAIL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_q) |-> $past(pend_q)); // R5
endmodule

// File: rtl/mbist_ram_mux.sv
module mbist_ram_mux #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              sel_eng,
  input  logic              eng_en,
  input  logic              eng_we,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic              fn_en,
  input  logic              fn_we,
  input  logic [ADDR_W-1:0] fn_addr,
  input  logic [DATA_W-1:0] fn_wdata,
  output logic [DATA_W-1:0] fn_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  always_comb begin
    if (sel_eng) begin
      ram_en    = eng_en;
      ram_we    = eng_en && eng_we;
      ram_addr  = eng_addr;
      ram_wdata = eng_wdata;
    end else begin
      ram_en    = fn_en;
      ram_we    = fn_en && fn_we;
      ram_addr  = fn_addr;
      ram_wdata = fn_wdata;
    end
  end

  assign fn_rdata = ram_rdata;
endmodule

// File: rtl/mbist_engine.sv
module mbist_engine #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 2,
  parameter int DATA_W   = 8,
  parameter int PERIOD   = 7,
  parameter int PAT_MUL  = 37,
  parameter int PAT_ADD  = 11,
  localparam int ADDR_W  = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_mode,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  input  logic              fn_en,
  input  logic              fn_we,
  input  logic [ADDR_W-1:0] fn_addr,
  input  logic [DATA_W-1:0] fn_wdata,
  output logic [DATA_W-1:0] fn_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  logic              start_acc;
  logic              eng_en;
  logic              eng_we;
  logic [ADDR_W-1:0] eng_addr;
  logic              invert;
  logic              pat_restart;
  logic              rd_issue;
  logic [DATA_W-1:0] pattern;
  logic              sel_eng;

  assign sel_eng = test_mode || busy;

  mbist_seq #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_seq (
    .clk(clk), .rst(rst), .test_mode(test_mode), .start(start),
    .start_acc(start_acc), .busy(busy), .done(done),
    .eng_en(eng_en), .eng_we(eng_we), .eng_addr(eng_addr),
    .invert(invert), .pat_restart(pat_restart), .rd_issue(rd_issue)
  );

  mbist_patgen #(.DATA_W(DATA_W), .PERIOD(PERIOD), .PAT_MUL(PAT_MUL),
                 .PAT_ADD(PAT_ADD)) u_patgen (
    .clk(clk), .rst(rst), .restart(pat_restart), .advance(eng_en),
    .invert(invert), .pattern(pattern)
  );

  mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .clear(start_acc), .rd_issue(rd_issue),
    .issue_addr(eng_addr), .issue_exp(pattern), .rd_data(ram_rdata),
    .fail(fail), .fail_addr(fail_addr)
  );

  mbist_ram_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .sel_eng(sel_eng), .eng_en(eng_en), .eng_we(eng_we),
    .eng_addr(eng_addr), .eng_wdata(pattern),
    .fn_en(fn_en), .fn_we(fn_we), .fn_addr(fn_addr), .fn_wdata(fn_wdata),
    .fn_rdata(fn_rdata), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  AST_FN_PASS: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && !busy) |-> (ram_en == fn_en && ram_addr == fn_addr)); // R9
  AST_FN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (test_mode && !busy) |-> !ram_en); // R10
endmodule

// File: tb/mbist_engine_tb.sv
module mbist_engine_tb;
  localparam int ROW_BITS = 3;
  localparam int COL_BITS = 2;
  localparam int DATA_W   = 8;
  localparam int PERIOD   = 7;
  localparam int PAT_MUL  = 37;
  localparam int PAT_ADD  = 11;
  localparam int AW       = ROW_BITS + COL_BITS;
  localparam int DEPTH    = 1 << AW;
  localparam int NCOL     = 1 << COL_BITS;

  logic clk = 1'b0;
  logic rst, test_mode, start, fn_en, fn_we;
  logic [AW-1:0] fn_addr;
  logic [DATA_W-1:0] fn_wdata, fn_rdata;
  logic busy, done, fail;
  logic [AW-1:0] fail_addr;
  logic ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int fault_mode = 0, f_sel = 0, f_bit = 0;
  logic [DATA_W-1:0] mem [DEPTH];

  always #10 clk = ~clk;

  mbist_engine #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W),
                 .PERIOD(PERIOD), .PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD)) u_dut (
    .clk(clk), .rst(rst), .test_mode(test_mode), .start(start),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fn_en(fn_en), .fn_we(fn_we), .fn_addr(fn_addr), .fn_wdata(fn_wdata),
    .fn_rdata(fn_rdata), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // fault model: 1 row alias, 2 column bit stuck at 1, 3 single cell bit flip, 4 column alias
  function automatic int map_addr(int a);
    int r = a / NCOL;
    int c = a % NCOL;
    if (fault_mode == 1 && r == f_sel) r = r ^ 1;
    if (fault_mode == 4 && c == f_sel) c = c ^ 1;
    return r * NCOL + c;
  endfunction

  function automatic logic [DATA_W-1:0] corrupt(int a, logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] v = d;
    if (fault_mode == 2 && (a % NCOL) == f_sel) v[f_bit] = 1'b1;
    if (fault_mode == 3 && a == f_sel) v[0] = ~v[0];
    return v;
  endfunction

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[map_addr(int'(ram_addr))] <= ram_wdata;
      else        ram_rdata <= corrupt(int'(ram_addr), mem[map_addr(int'(ram_addr))]);
    end
  end

  function automatic logic [DATA_W-1:0] pat_of(int a, bit inv);
    logic [DATA_W-1:0] p = DATA_W'((a % PERIOD) * PAT_MUL + PAT_ADD);
    return inv ? ~p : p;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic golden(output bit gf, output int ga);
    logic [DATA_W-1:0] g [DEPTH];
    gf = 0; ga = 0;
    for (int a = 0; a < DEPTH; a++) g[a] = '0;
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < DEPTH; a++) g[map_addr(a)] = pat_of(a, p[0]);
      for (int a = 0; a < DEPTH; a++)
        if (!gf && corrupt(a, g[map_addr(a)]) != pat_of(a, p[0])) begin
          gf = 1; ga = a;
        end
    end
  endtask

  task automatic run(string req, int mode, int sel, int bsel, bit poke_start, bit poke_fn);
    int n;
    bit gf;
    int ga;
    fault_mode = mode; f_sel = sel; f_bit = bsel;
    @(negedge clk);
    test_mode = 1; start = 1;
    if (poke_fn) begin
      fn_en = 1; fn_we = 1; fn_addr = AW'(3); fn_wdata = '0;
    end
    @(negedge clk);
    start = 0;
    chk({req, " busy after start (R3)"}, int'(busy), 1);
    chk({req, " done cleared (R11)"}, int'(done), 0);
    n = 0;
    while (n < 1000) begin
      @(negedge clk);
      n++;
      start = (poke_start && n == 10);
      if (done) break;
    end
    start = 0; fn_en = 0; fn_we = 0;
    golden(gf, ga);
    chk({req, " run length (R3)"}, n, 4 * DEPTH + 1);
    chk({req, " busy low at done (R3)"}, int'(busy), 0);
    chk({req, " fail flag"}, int'(fail), int'(gf));
    chk({req, " fail_addr"}, int'(fail_addr), ga);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1; test_mode = 0; start = 0; fn_en = 0; fn_we = 0;
    fn_addr = '0; fn_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 fail", int'(fail), 0);
    chk("R1 fail_addr", int'(fail_addr), 0);

    // functional pass-through
    fn_en = 1; fn_we = 1; fn_addr = AW'(5); fn_wdata = 8'hA5;
    #1;
    chk("R9 ram_en follows fn", int'(ram_en), 1);
    chk("R9 ram_addr follows fn", int'(ram_addr), 5);
    @(negedge clk); fn_we = 0;
    @(negedge clk); fn_en = 0;
    chk("R9 fn read back", int'(fn_rdata), 8'hA5);

    // functional blocked in test mode
    test_mode = 1;
    fn_en = 1; fn_we = 1; fn_addr = AW'(5); fn_wdata = 8'h3C;
    #1;
    chk("R10 ram_en blocked", int'(ram_en), 0);
    @(negedge clk);
    test_mode = 0; fn_we = 0;
    @(negedge clk); fn_en = 0;
    chk("R10 blocked write left data", int'(fn_rdata), 8'hA5);

    // start ignored with test_mode low
    start = 1;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    chk("R2 start ignored busy", int'(busy), 0);
    chk("R2 start ignored done", int'(done), 0);

    // clean run with a start poke and a functional write attempt mid-run
    run("R2 R10 clean", 0, 0, 0, 1, 1);
    test_mode = 0;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      fn_en = 1; fn_we = 0; fn_addr = AW'(a);
      @(negedge clk);
      fn_en = 0;
      chk($sformatf("R4 content addr %0d", a), int'(fn_rdata), int'(pat_of(a, 1)));
    end

    run("R6 row3 alias", 1, 3, 0, 0, 0);
    chk("R6 row alias detected", int'(fail), 1);
    chk("R6 row alias first addr", int'(fail_addr), 8);
    run("R6 row0 alias", 1, 0, 0, 0, 0);
    run("R7 column alias", 4, 1, 0, 0, 0);
    run("R7 column stuck bit", 2, 2, 3, 0, 0);
    run("R8 last address", 3, DEPTH - 1, 0, 0, 0);
    chk("R8 last address reported", int'(fail_addr), DEPTH - 1);
    run("R5 first address", 3, 0, 0, 0, 0);
    run("R11 clean after fault", 0, 0, 0, 0, 0);
    chk("R11 fail cleared", int'(fail), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule